// File: doc/BRIEF.md
# Event Timer Register Interface

This block is the memory-mapped register front end of a multi-channel event timer built around a 64-bit free-running main counter. It accepts one request per cycle over a valid/ready interface. A request carries a 10-bit byte offset inside a 1 KiB window, a length of 1 to 8 bytes and, for writes, data aligned to the low end of the data bus. Reads return the addressed bytes in the same cycle that the request is accepted. Writes merge only the addressed byte lanes into the 64-bit register. Each register then keeps its read-only bits.

The block stores the global control bits, the main counter, and three registers per channel: control, comparator and routing word. It also keeps a hidden period register for each channel. A capability word and a status word can be read. The main counter advances on an external `tick` strobe only while the global enable bit is set. The block emits one-cycle `ch_arm` and `ch_halt` pulses, which tell the downstream channel logic when to start or stop a channel's countdown. That channel logic handles comparison and interrupt delivery; this block does not.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset these values hold. The capability word reads {TICK_FS, 16'h8086, 8'hA2, 8'h01} (upper 32 bits are the tick period in femtoseconds). Global control, status, main counter, periods and routing words read 0. Every comparator reads all ones. Every channel control reads 64'h00F0_0000_0000_0030.
- R2: An access is rejected when its length is 0 or greater than 8, or when (offset & (length-1)) is nonzero. A rejected read returns all ones, and a rejected write changes no state.
- R3: An accepted read returns the 64-bit register at offset & ~7, shifted right by (offset & 7)·8 bits and masked to length·8 bits.
- R4: An accepted write replaces only bytes (offset & 7) through (offset & 7)+length-1 of the 64-bit register. Data byte 0 lands on the lowest of these bytes, and all other bytes keep their value.
- R5: Only bits [1:0] of global control (offset 0x010) are writable: bit 0 is enable, bit 1 is legacy routing. Channel control at 0x100+0x20·n accepts writes only on the bits of mask 0x3F4E: bit 2 enable, bit 3 periodic, bit 6 set-value, bit 8 32-bit mode, bits 13:9 route, bit 1 trigger type. All other bits hold.
- R6: The main counter (0x0F0) increments by one on each cycle in which `tick` is high and the enable bit is 1, and holds otherwise. A write to it takes effect in any state and overrides that cycle's increment.
- R7: A global enable 0→1 write pulses `ch_arm` for each channel whose enable bit is set. A 1→0 write pulses `ch_halt` for every channel.
- R8: With global enable at 1, a channel-control write that sets the channel's enable bit from 0 to 1 pulses that channel's `ch_arm`. A write that clears the bit from 1 to 0 pulses `ch_halt`, whatever the global enable.
- R9: A comparator write at 0x108+0x20·n is truncated to 32 bits when bit 8 is set. It goes to the period register when bit 3 is set and bit 6 is clear, and to the comparator otherwise. It always clears bit 6, and it pulses `ch_arm` when both the global and channel enables are set.
- R10: A channel-control write that leaves bit 8 set clears the upper 32 bits of that channel's comparator.
- R11: Reads of status (0x020), of the reserved offsets and of the fourth slot of each channel (0x118+0x20·n) return 0. Writes there change no state.
- R12: `req_ready` is asserted in every cycle in which `req_valid` is high, and `rsp_rdata` is 0 when no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset in the window |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, low-justified |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_rdata | output | 64 | Read data, low-justified |
| tick | input | 1 | Counter advance strobe |
| glb_en | output | 1 | Global enable bit |
| glb_legacy | output | 1 | Legacy routing bit |
| count_o | output | 64 | Main counter value |
| ch_cfg_o | output | NCH·16 | Low 16 bits of each channel control |
| ch_cmp_o | output | NCH·64 | Channel comparators |
| ch_period_o | output | NCH·64 | Channel periods |
| ch_route_o | output | NCH·64 | Channel routing words |
| ch_arm | output | NCH | Start pulse per channel |
| ch_halt | output | NCH | Stop pulse per channel |

## Verification
The assertions check the following on every cycle: all-ones on rejected reads, that the counter holds or steps by one according to enable and `tick`, that a falling enable halts all channels, that an arm never precedes a disabled global state, that arm and halt never coincide, that the channel capability bits stay fixed, and that reserved reads return zero. Only the bench's scenarios can show byte-lane merging, comparator routing to the period register, set-value clearing, truncation in 32-bit mode, and the exact cycles in which arm pulses occur. For this the bench compares every output against a behavioural model on each clock, under directed and random traffic.

// File: rtl/evt_timer_regs.sv
module evt_timer_regs #(
  parameter int NCH = 3,
  parameter logic [31:0] TICK_FS = 32'h0098_9680,
  parameter logic [15:0] VENDOR = 16'h8086,
  parameter logic [7:0] REV = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [9:0]        req_addr,
  input  logic [3:0]        req_len,
  input  logic [63:0]       req_wdata,
  output logic              req_ready,
  output logic [63:0]       rsp_rdata,
  input  logic              tick,
  output logic              glb_en,
  output logic              glb_legacy,
  output logic [63:0]       count_o,
  output logic [NCH*16-1:0] ch_cfg_o,
  output logic [NCH*64-1:0] ch_cmp_o,
  output logic [NCH*64-1:0] ch_period_o,
  output logic [NCH*64-1:0] ch_route_o,
  output logic [NCH-1:0]    ch_arm,
  output logic [NCH-1:0]    ch_halt
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [9:0] CH_BASE = 10'h100;
  localparam logic [9:0] CH_END = 10'(256 + 32 * NCH);
  localparam logic [15:0] CFG_WMASK = 16'h3F4E;
  localparam logic [15:0] CFG_RST = 16'h0030;
  localparam logic [4:0] NT_FIELD = 5'(NCH - 1);
  localparam logic [63:0] CAP = {TICK_FS, VENDOR, 1'b1, 1'b0, 1'b1, NT_FIELD, REV};

  logic [1:0]  gcfg;
  logic [63:0] cnt;
  logic [15:0] ccfg [NCH];
  logic [63:0] cmp  [NCH];
  logic [63:0] per  [NCH];
  logic [63:0] rt   [NCH];

  logic [9:0]  off;
  logic [5:0]  sh8;
  logic        bad, wr, in_ch, wr_cfg, wr_cnt, g_rise, g_fall;
  logic [1:0]  slot;
  logic [CW-1:0] idx;
  logic [63:0] lmask, lanes, old_val, merged;
  logic [15:0] new_cfg [NCH];
  logic [63:0] cmp_val [NCH];
  logic [NCH-1:0] cfg_hit, cmp_hit, rt_hit;

  assign off   = {req_addr[9:3], 3'b000};
  assign sh8   = {req_addr[2:0], 3'b000};
  assign bad   = (req_len == 4'd0) || (req_len > 4'd8) ||
                 ((req_addr & {6'b0, req_len - 4'd1}) != 10'd0);
  assign lmask = (req_len >= 4'd8) ? '1 : ((64'd1 << {req_len, 3'b000}) - 64'd1);
  assign lanes = lmask << sh8;
  assign in_ch = (off >= CH_BASE) && (off < CH_END);
  assign idx   = CW'((off - CH_BASE) >> 5);
  assign slot  = off[4:3];
  assign wr    = req_valid && req_write && !bad;
  assign wr_cfg = wr && (off == 10'h010);
  assign wr_cnt = wr && (off == 10'h0F0);

  always_comb begin
    old_val = '0;
    if (off == 10'h000) old_val = CAP;
    else if (off == 10'h010) old_val = {62'd0, gcfg};
    else if (off == 10'h0F0) old_val = cnt;
    else if (in_ch) begin
      case (slot)
        2'd0: old_val = {32'h00F0_0000, 16'h0000, ccfg[idx]};
        2'd1: old_val = cmp[idx];
        2'd2: old_val = rt[idx];
        default: old_val = '0;
      endcase
    end
  end

  assign merged    = ((req_wdata << sh8) & lanes) | (old_val & ~lanes);
  assign req_ready = req_valid;
  assign rsp_rdata = (!req_valid || req_write) ? '0 :
                     bad ? '1 : ((old_val >> sh8) & lmask);

  assign g_rise = wr_cfg && merged[0] && !gcfg[0];
  assign g_fall = wr_cfg && !merged[0] && gcfg[0];

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      cfg_hit[n] = wr && in_ch && (idx == CW'(n)) && (slot == 2'd0);
      cmp_hit[n] = wr && in_ch && (idx == CW'(n)) && (slot == 2'd1);
      rt_hit[n]  = wr && in_ch && (idx == CW'(n)) && (slot == 2'd2);
      new_cfg[n] = (merged[15:0] & CFG_WMASK) | (ccfg[n] & ~CFG_WMASK);
      cmp_val[n] = ccfg[n][8] ? {32'h0, merged[31:0]} : merged;
      ch_arm[n]  = (g_rise && ccfg[n][2]) ||
                   (cfg_hit[n] && gcfg[0] && new_cfg[n][2] && !ccfg[n][2]) ||
                   (cmp_hit[n] && gcfg[0] && ccfg[n][2]);
      ch_halt[n] = g_fall || (cfg_hit[n] && ccfg[n][2] && !new_cfg[n][2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcfg <= 2'b00;
      cnt  <= '0;
      for (int n = 0; n < NCH; n++) begin
        ccfg[n] <= CFG_RST;
        cmp[n]  <= '1;
        per[n]  <= '0;
        rt[n]   <= '0;
      end
    end else begin
      if (wr_cfg) gcfg <= merged[1:0];
      if (wr_cnt) cnt <= merged;
      else if (gcfg[0] && tick) cnt <= cnt + 64'd1;
      for (int n = 0; n < NCH; n++) begin
        if (cfg_hit[n]) begin
          ccfg[n] <= new_cfg[n];
          if (new_cfg[n][8]) cmp[n] <= {32'h0, cmp[n][31:0]};
        end
        if (cmp_hit[n]) begin
          if (ccfg[n][3] && !ccfg[n][6]) per[n] <= cmp_val[n];
          else cmp[n] <= cmp_val[n];
          ccfg[n][6] <= 1'b0;
        end
        if (rt_hit[n]) rt[n] <= merged;
      end
    end
  end

  assign glb_en     = gcfg[0];
  assign glb_legacy = gcfg[1];
  assign count_o    = cnt;

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign ch_cfg_o[g*16 +: 16]    = ccfg[g];
    assign ch_cmp_o[g*64 +: 64]    = cmp[g];
    assign ch_period_o[g*64 +: 64] = per[g];
    assign ch_route_o[g*64 +: 64]  = rt[g];
  end
endmodule

// File: rtl/evt_timer_regs_chk.sv
module evt_timer_regs_chk #(
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [9:0]        req_addr,
  input logic [3:0]        req_len,
  input logic [63:0]       rsp_rdata,
  input logic              tick,
  input logic              glb_en,
  input logic [63:0]       count_o,
  input logic [NCH*16-1:0] ch_cfg_o,
  input logic [NCH-1:0]    ch_arm,
  input logic [NCH-1:0]    ch_halt
);
  logic rej, cnt_wr, rsv_rd;
  assign rej    = (req_len == 4'd0) || (req_len > 4'd8) ||
                  ((req_addr[2:0] & 3'(req_len - 4'd1)) != 3'd0);
  assign cnt_wr = req_valid && req_write && !rej && (req_addr[9:3] == 7'h1E);
  assign rsv_rd = req_valid && !req_write && !rej &&
                  (req_addr[9:3] >= 7'h05) && (req_addr[9:3] <= 7'h1D);

  a_r2_reject_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && rej) |-> (rsp_rdata == '1));

  a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !cnt_wr) |=> $stable(count_o));

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && tick && !cnt_wr) |=> (count_o == $past(count_o) + 64'd1));

  a_r7_fall_halts_all: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glb_en) |-> ($past(ch_halt) == '1));

  a_r8_arm_leaves_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_arm != '0) |=> glb_en);

  a_r8_arm_halt_apart: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_arm & ch_halt) == '0));

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_rd |-> (rsp_rdata == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_caps
    a_r5_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
      ((ch_cfg_o[g*16 +: 16] & 16'hC0B1) == 16'h0030));
  end
endmodule

bind evt_timer_regs evt_timer_regs_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_len(req_len), .rsp_rdata(rsp_rdata), .tick(tick),
  .glb_en(glb_en), .count_o(count_o), .ch_cfg_o(ch_cfg_o),
  .ch_arm(ch_arm), .ch_halt(ch_halt)
);

// File: tb/evt_timer_regs_tb.sv
`timescale 1ns/1ps
module evt_timer_regs_tb;
  localparam int NCH = 3;
  localparam logic [63:0] CAP_EXP = 64'h0098_9680_8086_A201;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, tick = 0;
  logic [9:0] req_addr = '0;
  logic [3:0] req_len = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, glb_en, glb_legacy;
  logic [63:0] rsp_rdata, count_o;
  logic [NCH*16-1:0] ch_cfg_o;
  logic [NCH*64-1:0] ch_cmp_o, ch_period_o, ch_route_o;
  logic [NCH-1:0] ch_arm, ch_halt;

  always #2.5 clk = ~clk;

  evt_timer_regs #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .tick(tick),
    .glb_en(glb_en), .glb_legacy(glb_legacy), .count_o(count_o),
    .ch_cfg_o(ch_cfg_o), .ch_cmp_o(ch_cmp_o), .ch_period_o(ch_period_o),
    .ch_route_o(ch_route_o), .ch_arm(ch_arm), .ch_halt(ch_halt)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [1:0]  m_g;
  logic [63:0] m_cnt;
  logic [63:0] m_ccfg [NCH];
  logic [63:0] m_cmp  [NCH];
  logic [63:0] m_per  [NCH];
  logic [63:0] m_rt   [NCH];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] m_read64(input int o);
    if (o == 'h000) return CAP_EXP;
    if (o == 'h010) return {62'd0, m_g};
    if (o == 'h0F0) return m_cnt;
    if (o >= 'h100 && o < 'h100 + 32 * NCH) begin
      int n = (o - 'h100) / 32;
      int s = ((o - 'h100) % 32) / 8;
      if (s == 0) return m_ccfg[n];
      if (s == 1) return m_cmp[n];
      if (s == 2) return m_rt[n];
    end
    return 64'd0;
  endfunction

  task automatic cyc(input logic v, input logic w, input int ad, input int ln,
                     input logic [63:0] d, input logic tk, input string tag);
    int a, o, sh, n, s;
    bit bad;
    logic [63:0] old, rd, mg;
    logic [NCH-1:0] earm, ehalt;
    logic [1:0]  x_g;
    logic [63:0] x_cnt;
    logic [63:0] x_ccfg [NCH];
    logic [63:0] x_cmp  [NCH];
    logic [63:0] x_per  [NCH];
    logic [63:0] x_rt   [NCH];
    bit cnt_written;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = 10'(ad); req_len = 4'(ln);
    req_wdata = d; tick = tk;
    #1;
    a = ad % 1024; o = a - (a % 8); sh = a % 8;
    bad = (ln == 0) || (ln > 8) || ((a & (ln - 1)) != 0);
    old = m_read64(o);
    rd = 64'd0; mg = old;
    for (int b = 0; b < 8; b++)
      if (b < ln && sh + b < 8) begin
        rd[8*b +: 8] = old[8*(sh+b) +: 8];
        mg[8*(sh+b) +: 8] = d[8*b +: 8];
      end
    if (bad) rd = '1;
    x_g = m_g; x_cnt = m_cnt; earm = '0; ehalt = '0; cnt_written = 0;
    for (int i = 0; i < NCH; i++) begin
      x_ccfg[i] = m_ccfg[i]; x_cmp[i] = m_cmp[i]; x_per[i] = m_per[i]; x_rt[i] = m_rt[i];
    end
    if (v && w && !bad) begin
      if (o == 'h010) begin
        x_g = mg[1:0];
        for (int i = 0; i < NCH; i++) begin
          if (!m_g[0] && mg[0] && m_ccfg[i][2]) earm[i] = 1;
          if (m_g[0] && !mg[0]) ehalt[i] = 1;
        end
      end else if (o == 'h0F0) begin
        x_cnt = mg; cnt_written = 1;
      end else if (o >= 'h100 && o < 'h100 + 32 * NCH) begin
        n = (o - 'h100) / 32; s = ((o - 'h100) % 32) / 8;
        if (s == 0) begin
          x_ccfg[n] = (mg & 64'h3F4E) | (m_ccfg[n] & ~64'h3F4E);
          if (x_ccfg[n][8]) x_cmp[n] = m_cmp[n] & 64'hFFFF_FFFF;
          if (!m_ccfg[n][2] && x_ccfg[n][2] && m_g[0]) earm[n] = 1;
          if (m_ccfg[n][2] && !x_ccfg[n][2]) ehalt[n] = 1;
        end else if (s == 1) begin
          if (m_ccfg[n][8]) mg = mg & 64'hFFFF_FFFF;
          if (m_ccfg[n][3] && !m_ccfg[n][6]) x_per[n] = mg;
          else x_cmp[n] = mg;
          x_ccfg[n][6] = 1'b0;
          if (m_g[0] && m_ccfg[n][2]) earm[n] = 1;
        end else if (s == 2) begin
          x_rt[n] = mg;
        end
      end
    end
    if (!cnt_written && m_g[0] && tk) x_cnt = m_cnt + 1;

    chk(rsp_rdata == ((v && !w) ? rd : 64'd0), tag, rsp_rdata, (v && !w) ? rd : 64'd0);
    chk(req_ready == v, "R12 ready", 64'(req_ready), 64'(v));
    chk(ch_arm == earm, "R7 R8 R9 arm", 64'(ch_arm), 64'(earm));
    chk(ch_halt == ehalt, "R7 R8 halt", 64'(ch_halt), 64'(ehalt));
    chk(count_o == m_cnt, "R6 counter", count_o, m_cnt);
    chk({glb_legacy, glb_en} == m_g, "R5 global bits", 64'({glb_legacy, glb_en}), 64'(m_g));
    for (int i = 0; i < NCH; i++) begin
      chk(ch_cfg_o[i*16 +: 16] == m_ccfg[i][15:0], "R5 R10 channel control",
          64'(ch_cfg_o[i*16 +: 16]), m_ccfg[i]);
      chk(ch_cmp_o[i*64 +: 64] == m_cmp[i], "R9 R10 comparator", ch_cmp_o[i*64 +: 64], m_cmp[i]);
      chk(ch_period_o[i*64 +: 64] == m_per[i], "R9 period", ch_period_o[i*64 +: 64], m_per[i]);
      chk(ch_route_o[i*64 +: 64] == m_rt[i], "R4 R11 route", ch_route_o[i*64 +: 64], m_rt[i]);
    end
    @(posedge clk);
    m_g = x_g; m_cnt = x_cnt;
    for (int i = 0; i < NCH; i++) begin
      m_ccfg[i] = x_ccfg[i]; m_cmp[i] = x_cmp[i]; m_per[i] = x_per[i]; m_rt[i] = x_rt[i];
    end
  endtask

  task automatic rd_lit(input int ad, input int ln, input logic [63:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 10'(ad); req_len = 4'(ln); tick = 0;
    #1;
    chk(rsp_rdata == exp, tag, rsp_rdata, exp);
    @(posedge clk);
  endtask

  task automatic idle(input int k, input logic tk);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 64'd0, tk, "R12 idle");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_g = 2'b00; m_cnt = 0;
    for (int i = 0; i < NCH; i++) begin
      m_ccfg[i] = 64'h00F0_0000_0000_0030; m_cmp[i] = '1; m_per[i] = 0; m_rt[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset values
    rd_lit('h000, 8, CAP_EXP, "R1 capability");
    rd_lit('h120, 8, 64'h00F0_0000_0000_0030, "R1 channel control");
    rd_lit('h148, 8, '1, "R1 comparator");
    rd_lit('h0F0, 8, 64'd0, "R1 counter");
    cyc(1, 0, 'h010, 8, 0, 0, "R1 global control");

    // R3 narrow reads
    rd_lit('h001, 1, 64'hA2, "R3 byte read");
    rd_lit('h002, 2, 64'h8086, "R3 half read");
    rd_lit('h004, 4, 64'h0098_9680, "R3 word read");
    cyc(1, 0, 'h005, 3, 0, 0, "R3 three-byte read");

    // R2 rejected accesses
    rd_lit('h003, 2, '1, "R2 misaligned read");
    cyc(1, 0, 'h000, 9, 0, 0, "R2 oversize read");
    cyc(1, 0, 'h000, 0, 0, 0, "R2 zero length read");
    cyc(1, 1, 'h011, 2, 64'hFFFF, 0, "R2 dropped write");
    cyc(1, 1, 'h112, 4, '1, 0, "R2 dropped write");

    // R4 lane merge
    cyc(1, 1, 'h110, 8, 64'h1122_3344_5566_7788, 0, "R4 full write");
    cyc(1, 1, 'h112, 2, 64'hFFFF_FFFF_FFFF_ABCD, 0, "R4 half write");
    rd_lit('h110, 8, 64'h1122_3344_ABCD_7788, "R4 merged value");
    cyc(1, 1, 'h137, 1, 64'h5A, 0, "R4 top byte");

    // R5 write masks, R10 truncation
    cyc(1, 1, 'h100, 8, '1, 0, "R5 channel control");
    rd_lit('h100, 8, 64'h00F0_0000_0000_3F7E, "R5 channel mask");
    rd_lit('h108, 8, 64'h0000_0000_FFFF_FFFF, "R10 truncated comparator");
    cyc(1, 1, 'h100, 2, 64'h0004, 0, "R5 clear bits");

    // R6 counter
    cyc(1, 1, 'h0F0, 8, 64'd100, 1, "R6 write halted");
    idle(3, 1);
    rd_lit('h0F0, 8, 64'd100, "R6 hold while halted");
    cyc(1, 1, 'h010, 1, 64'h01, 1, "R7 enable rise");
    idle(4, 1);
    idle(2, 0);
    rd_lit('h0F0, 8, 64'd104, "R6 advance");
    cyc(1, 1, 'h0F4, 4, 64'h1, 1, "R6 write running");

    // R8 channel edges with global on
    cyc(1, 1, 'h120, 1, 64'h04, 0, "R8 channel arm");
    cyc(1, 1, 'h120, 1, 64'h00, 0, "R8 channel halt");
    cyc(1, 1, 'h120, 1, 64'h04, 0, "R8 channel rearm");

    // R9 comparator routing
    cyc(1, 1, 'h140, 2, 64'h010C, 0, "R9 periodic 32-bit");
    cyc(1, 1, 'h148, 8, 64'hDEAD_BEEF_0000_0040, 0, "R9 period write");
    cyc(1, 1, 'h140, 1, 64'h4C, 0, "R9 set-value");
    cyc(1, 1, 'h148, 8, 64'hCAFE_0000_0000_0800, 0, "R9 comparator write");
    cyc(1, 1, 'h128, 8, 64'h0000_0001_0000_0000, 0, "R9 wide arm");

    // R7 falling edge
    cyc(1, 1, 'h010, 8, 64'h02, 1, "R7 enable fall");
    idle(2, 1);
    cyc(1, 1, 'h010, 1, 64'h03, 0, "R7 rise both");
    cyc(1, 1, 'h010, 1, 64'h00, 0, "R7 fall");

    // R11 reserved
    rd_lit('h020, 8, 64'd0, "R11 status");
    rd_lit('h040, 8, 64'd0, "R11 reserved read");
    rd_lit('h118, 8, 64'd0, "R11 slot read");
    rd_lit('h170, 8, 64'd0, "R11 beyond channels");
    cyc(1, 1, 'h040, 8, '1, 0, "R11 reserved write");
    cyc(1, 1, 'h118, 8, '1, 0, "R11 slot write");
    cyc(1, 1, 'h000, 8, 64'd0, 0, "R11 capability write");
    rd_lit('h000, 8, CAP_EXP, "R11 capability kept");

    // random traffic
    for (int i = 0; i < 600; i++) begin
      int offs [15] = '{'h000, 'h010, 'h020, 'h0F0, 'h100, 'h108, 'h110, 'h120,
                        'h128, 'h130, 'h140, 'h148, 'h150, 'h040, 'h118};
      int lens [6] = '{1, 2, 4, 8, 3, 9};
      int ad = offs[$urandom_range(14)] + $urandom_range(7);
      int ln = lens[$urandom_range(5)];
      logic [63:0] d = {$urandom, $urandom};
      if (ad % 8 == 0 && $urandom_range(3) == 0) ln = 8;
      cyc($urandom_range(3) != 0, $urandom_range(1) == 1, ad, ln, d,
          $urandom_range(1) == 1, "R3 R4 random");
    end

    idle(2, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule